// File: doc/BRIEF.md
# Endian-Switchable Byte-Lane Load/Store Unit

This unit sits between a processor's load/store path and a 32-bit memory addressed to the byte. Each request carries a byte address, a size (byte, halfword or word), a load/store flag, store data, a signed/unsigned load flag and a byte-order mode bit. The byte-order mode may change from one request to the next. The unit turns the request into a word address, per-lane write enables and lane-steered store data for the memory. For loads, it turns the word that comes back into a result that starts at bit 0 and is sign- or zero-extended.

The unit checks every request for natural alignment. A request that crosses its natural boundary raises a one-cycle fault and is never issued to memory. The memory is assumed to be synchronous: a read word appears on `mem_rdata` one clock after the unit presents an enabled read.

Physical lane k of the memory word is bits [8k+7:8k]. In little-endian mode, the byte at address offset o (the low two address bits) lives in lane o. In big-endian mode, it lives in lane 3-o. Under this mapping a whole word has the same bit layout in both modes. What changes between the modes is the order in which bytes and halfwords are numbered.

Top module: `endian_lsu`

## Requirements
- R1: One cycle after an accepted request, `mem_addr` equals the request address with bits [1:0] cleared, and `mem_en` is 1.
- R2: A request is faulted when `req_size` is 2 (word) and address bits [1:0] are not 00, when `req_size` is 1 (halfword) and address bit 0 is 1, or when `req_size` is 3. In the cycle after a faulted request, `misaligned` is 1 for exactly that cycle, `mem_en` is 0 and `mem_we` is 0. A faulted store leaves memory unchanged, and a faulted load produces no `load_valid`.
- R3: With `big_endian`=0, a store's `mem_we` selects lane o for a byte, lanes o and o+1 for a halfword, and all four lanes for a word.
- R4: With `big_endian`=1, a store's `mem_we` selects lane 3-o for a byte, lanes 3-o and 2-o for a halfword, and all four lanes for a word.
- R5: Store data on `mem_wdata` is `req_wdata[7:0]` repeated four times for a byte, `req_wdata[15:0]` repeated twice for a halfword, and `req_wdata` unchanged for a word.
- R6: A byte load returns the byte from the lane selected per R3/R4 in bits [7:0]. The upper bits are copies of its bit 7 when `req_signed`=1 and zero otherwise.
- R7: In a halfword load the lower-addressed byte supplies bits [7:0] in little-endian mode and bits [15:8] in big-endian mode. The result is extended as in R6, using bit 15.
- R8: A word load at address a equals the four byte loads at a..a+3 combined. In little-endian mode the byte at a+i supplies bits [8i+7:8i]. In big-endian mode it supplies bits [31-8i:24-8i].
- R9: A load request drives `mem_we` to 0 with `mem_en` 1. `load_valid` is 1 for one cycle, two cycles after the request is sampled, and `load_data` is 0 whenever `load_valid` is 0.
- R10: During and after reset with no request, `mem_en`, `mem_we`, `misaligned` and `load_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| req_signed | input | 1 | Sign-extend a load result |
| big_endian | input | 1 | Byte-order mode for this request |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Read word, valid one cycle after an enabled read |
| misaligned | output | 1 | One-cycle alignment fault |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |

## Verification
The memory-side outputs and the fault pulse come from registers loaded at the edge that samples the request. The bench reads them at the falling edge that follows. The load result depends on one more edge, the one at which the memory model answers, so the bench reads `load_valid` and `load_data` at the next falling edge. That second sample also confirms that a faulted load produced no result. Each request is followed by an idle cycle, so results from one request never overlap the sampling window of the next.

// File: rtl/endian_lsu.sv
module endian_lsu #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_signed,
  input  logic              big_endian,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en,
  output logic [3:0]        mem_we,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              misaligned,
  output logic              load_valid,
  output logic [31:0]       load_data
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  logic [1:0]  off, lane;
  logic        bad, go;
  logic [3:0]  lanes;
  logic [31:0] steered;

  assign off  = req_addr[1:0];
  assign lane = big_endian ? ~off : off;
  assign bad  = (req_size == 2'd3) || (req_size == SZ_W && off != 2'd0) ||
                (req_size == SZ_H && off[0]);
  assign go   = req_valid && !bad;

  always_comb begin
    case (req_size)
      SZ_B:    begin lanes = 4'b0001 << lane; steered = {4{req_wdata[7:0]}}; end
      SZ_H:    begin lanes = lane[1] ? 4'b1100 : 4'b0011; steered = {2{req_wdata[15:0]}}; end
      default: begin lanes = 4'b1111; steered = req_wdata; end
    endcase
  end

  logic [1:0] ld1_lane, ld1_size, ld2_lane, ld2_size;
  logic       ld1_go, ld1_sgn, ld2_sgn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_en     <= 1'b0;
      mem_we     <= 4'b0;
      mem_wdata  <= '0;
      misaligned <= 1'b0;
      ld1_go     <= 1'b0;
      ld1_lane   <= '0;
      ld1_size   <= '0;
      ld1_sgn    <= 1'b0;
      load_valid <= 1'b0;
      ld2_lane   <= '0;
      ld2_size   <= '0;
      ld2_sgn    <= 1'b0;
    end else begin
      mem_addr   <= {req_addr[ADDR_W-1:2], 2'b00};
      mem_en     <= go;
      mem_we     <= (go && req_store) ? lanes : 4'b0;
      mem_wdata  <= (go && req_store) ? steered : '0;
      misaligned <= req_valid && bad;
      ld1_go     <= go && !req_store;
      ld1_lane   <= lane;
      ld1_size   <= req_size;
      ld1_sgn    <= req_signed;
      load_valid <= ld1_go;
      ld2_lane   <= ld1_lane;
      ld2_size   <= ld1_size;
      ld2_sgn    <= ld1_sgn;
    end
  end

  logic [31:0] shifted, ext;
  assign shifted = mem_rdata >> {ld2_lane, 3'b000};

  always_comb begin
    case (ld2_size)
      SZ_B: ext = {{24{ld2_sgn & shifted[7]}}, shifted[7:0]};
      SZ_H: ext = ld2_lane[1] ? {{16{ld2_sgn & mem_rdata[31]}}, mem_rdata[31:16]}
                              : {{16{ld2_sgn & mem_rdata[15]}}, mem_rdata[15:0]};
      default: ext = mem_rdata;
    endcase
  end

  assign load_data = load_valid ? ext : '0;
endmodule

module endian_lsu_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_en,
  input logic [3:0]        mem_we,
  input logic              misaligned,
  input logic              load_valid
);
  // R1
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr[1:0] == 2'b00);
  // R2
  word_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> (misaligned && !mem_en));
  // R2
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (!mem_en && mem_we == 4'b0));
  // R3
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != 4'b0) |-> (mem_en && ($countones(mem_we) == 1 || $countones(mem_we) == 2 ||
                                     $countones(mem_we) == 4)));
  // R9
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> ($past(mem_en) && $past(mem_we) == 4'b0));
endmodule

bind endian_lsu endian_lsu_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .req_addr(req_addr), .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we),
  .misaligned(misaligned), .load_valid(load_valid)
);

// File: tb/endian_lsu_tb.sv
module endian_lsu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_signed = 0, big_endian = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [AW-1:0] mem_addr;
  logic mem_en, misaligned, load_valid;
  logic [3:0] mem_we;
  logic [31:0] mem_wdata, load_data;
  logic [31:0] mem_rdata = 0;

  int checks = 0, fails = 0;
  logic [31:0] mem_model [16];
  logic [7:0]  ref_lane [16][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_lsu #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_signed(req_signed), .big_endian(big_endian), .mem_addr(mem_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .misaligned(misaligned), .load_valid(load_valid), .load_data(load_data)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem_model[mem_addr[5:2]];
      for (int k = 0; k < 4; k++)
        if (mem_we[k]) mem_model[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lane_of(int a, bit be);
    return be ? 3 - (a % 4) : a % 4;
  endfunction

  function automatic bit is_bad(int sz, int a);
    return sz == 3 || (sz == 2 && a % 4 != 0) || (sz == 1 && a % 2 != 0);
  endfunction

  task automatic access(bit st, int sz, int a, logic [31:0] d, bit sg, bit be);
    int n = 1 << sz;
    bit bad = is_bad(sz, a);
    logic [3:0] exp_we = 0;
    logic [31:0] exp_wd, exp_ld = 0;
    string lreq = (sz == 0) ? "R6" : (sz == 1) ? "R7" : "R8";
    string wreq = be ? "R4" : "R3";
    exp_wd = (sz == 0) ? {4{d[7:0]}} : (sz == 1) ? {2{d[15:0]}} : d;
    if (!bad) begin
      for (int i = 0; i < n; i++) begin
        int bi = be ? (n - 1 - i) : i;
        int ln = lane_of(a + i, be);
        exp_we[ln] = 1'b1;
        exp_ld[8*bi +: 8] = ref_lane[(a >> 2) % 16][ln];
        if (st) ref_lane[(a >> 2) % 16][ln] = d[8*bi +: 8];
      end
      if (sg && n == 1 && exp_ld[7])  exp_ld[31:8]  = '1;
      if (sg && n == 2 && exp_ld[15]) exp_ld[31:16] = '1;
    end
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = sz[1:0]; req_addr = a;
    req_wdata = d; req_signed = sg; big_endian = be;
    @(negedge clk);
    req_valid = 0;
    check("R2 misaligned", {31'b0, misaligned}, {31'b0, bad});
    check("R2/R1 mem_en", {31'b0, mem_en}, {31'b0, !bad});
    if (!bad) check("R1 mem_addr", mem_addr, a & ~32'd3);
    if (st) begin
      check(bad ? "R2 mem_we" : wreq, {28'b0, mem_we}, {28'b0, exp_we});
      if (!bad) check("R5 mem_wdata", mem_wdata, exp_wd);
    end else check("R9 load mem_we", {28'b0, mem_we}, 32'd0);
    @(negedge clk);
    check("R9 load_valid", {31'b0, load_valid}, {31'b0, (!st && !bad)});
    if (!st && !bad) check(lreq, load_data, exp_ld);
    @(negedge clk);
    check("R9 load_data idle", load_data, 32'd0);
  endtask

  initial begin
    for (int w = 0; w < 16; w++)
      for (int l = 0; l < 4; l++) begin
        ref_lane[w][l] = 8'(8'hA0 + w * 4 + l);
        mem_model[w][8*l +: 8] = 8'(8'hA0 + w * 4 + l);
      end
    repeat (3) @(negedge clk);
    // R10
    check("R10 mem_en", {31'b0, mem_en}, 0);
    check("R10 mem_we", {28'b0, mem_we}, 0);
    check("R10 misaligned", {31'b0, misaligned}, 0);
    check("R10 load_valid", {31'b0, load_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle mem_en", {31'b0, mem_en}, 0);

    // R8 little-endian: word then bytes
    access(1, 2, 0, 32'h11223344, 0, 0);
    access(0, 0, 0, 0, 0, 0); access(0, 0, 1, 0, 0, 0);
    access(0, 0, 2, 0, 0, 0); access(0, 0, 3, 0, 0, 0);
    access(0, 1, 2, 0, 0, 0);
    // R8 big-endian
    access(1, 2, 4, 32'h11223344, 0, 1);
    access(0, 0, 4, 0, 0, 1); access(0, 0, 7, 0, 0, 1);
    access(0, 1, 4, 0, 0, 1); access(0, 2, 4, 0, 0, 0);
    // R6 sign and zero extension
    access(1, 0, 9, 32'hFFFF_FF80, 0, 1);
    access(0, 0, 9, 0, 1, 1); access(0, 0, 9, 0, 0, 1);
    // R7 halfword sign
    access(1, 1, 14, 32'h0000_8001, 0, 0);
    access(0, 1, 14, 0, 1, 0); access(0, 1, 14, 0, 1, 1);
    // R2 faulted store leaves memory unchanged
    access(1, 2, 17, 32'hDEADBEEF, 0, 0);
    access(1, 1, 19, 32'hDEADBEEF, 0, 1);
    access(1, 3, 16, 32'hDEADBEEF, 0, 0);
    access(0, 2, 16, 0, 0, 0);
    access(0, 1, 21, 0, 0, 0);

    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 400; it++) begin
      int sz = $urandom % 4;
      int a  = $urandom % 64;
      if ($urandom % 4 != 0) begin
        if (sz == 2) a = a & ~3;
        if (sz == 1) a = a & ~1;
      end
      access($urandom % 2, sz, a, $urandom, $urandom % 2, $urandom % 2);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule